// File: doc/BRIEF.md
# Cache Tag Store with Hit Comparator

This block keeps the tag half of a direct-mapped cache. Every entry carries a tag word together with a valid flag and a dirty flag, and one index input selects the entry for all operations. Writes happen on the rising clock edge. Lookups are combinational: the stored tag, the flags and the hit signal follow the index and the presented tag within the same cycle, without waiting for a clock edge.

Two active-low controls select the mode. A write enable stores the presented tag and flags, and an output enable places the stored tag on the readback bus. When both are high the block compares, and the hit output is high only for a valid entry whose tag equals the presented one. An active-low clear wipes the valid and dirty flags of every entry in a single edge. After the clear, writes are locked out for a set number of edges so that the flags settle before new contents arrive. The shared tag bus is modelled as a data output plus a drive-enable flag.

Top module: `tag_ram_cmp`

## Requirements
- R1: At a rising edge where we_ni=0, oe_ni=1, clr_ni=1 and no clear recovery is pending, tag_i, valid_i and dirty_i are stored in entry idx_i. No other entry changes.
- R2: While we_ni=0, oe_ni=1 and clr_ni=1, valid_o equals valid_i, dirty_o equals dirty_i, match_o is 0 and tag_oe_o is 0. This holds even if the write itself is blocked.
- R3: While we_ni=1, oe_ni=1 and clr_ni=1, match_o is 1 exactly when the stored valid flag of entry idx_i is 1 and tag_i equals its stored tag. The output follows idx_i and tag_i combinationally.
- R4: Outside write and clear cycles, valid_o and dirty_o show the stored flags of entry idx_i combinationally.
- R5: While oe_ni=0, we_ni=1 and clr_ni=1, tag_oe_o is 1, tag_o carries the stored tag of entry idx_i, and match_o is 0.
- R6: When we_ni=0 and oe_ni=0 together, nothing is stored, and the outputs behave as in R5.
- R7: At an edge where clr_ni=0, the valid and dirty flags of every entry are cleared and the stored tags are kept. While clr_ni=0, match_o, valid_o, dirty_o and tag_oe_o are all 0.
- R8: A write is ignored at each of the CLR_RECOV rising edges that follow the last edge with clr_ni=0. A write at the next edge after those is accepted.
- R9: While rst_ni=0, all flags, all stored tags and the recovery lockout are cleared asynchronously. A write at the first edge after reset is accepted.
- R10: tag_o is all zeros whenever tag_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | IDX_W | Entry index |
| tag_i | input | TAG_W | Tag to store or to compare |
| valid_i | input | 1 | Valid flag to store |
| dirty_i | input | 1 | Dirty flag to store |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Tag readback enable, active low |
| clr_ni | input | 1 | Clear of all flags, active low |
| tag_o | output | TAG_W | Stored tag for readback |
| tag_oe_o | output | 1 | High when tag_o drives the shared tag bus |
| match_o | output | 1 | Hit: valid entry with equal tag |
| valid_o | output | 1 | Valid flag (stored or pass-through) |
| dirty_o | output | 1 | Dirty flag (stored or pass-through) |

## Verification
The functions that can collide in one cycle are the flash clear and a write request. A write can arrive while clr_ni is low, or during the lockout edges after the clear. The bench raises write requests on consecutive cycles straight after a clear, and each one targets a different entry with a different tag. It then sweeps every entry in readback and compare modes. Only the entry written after the lockout may hold a set valid flag, and all earlier tags must still be present.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

  typedef enum logic [2:0] {
    MODE_CLEAR,
    MODE_WRITE,
    MODE_READ,
    MODE_ILLEGAL,
    MODE_COMPARE
  } tag_mode_e;

  // clear dominates; write+readback together is the forbidden combination
  function automatic tag_mode_e decode_mode(logic clr_n, logic we_n, logic oe_n);
    if (!clr_n)              return MODE_CLEAR;
    else if (!we_n && !oe_n) return MODE_ILLEGAL;
    else if (!we_n)          return MODE_WRITE;
    else if (!oe_n)          return MODE_READ;
    else                     return MODE_COMPARE;
  endfunction

endpackage

// File: rtl/tagram_mode_dec.sv
module tagram_mode_dec
  import tagram_pkg::*;
(
  input  logic      clr_ni,
  input  logic      we_ni,
  input  logic      oe_ni,
  output tag_mode_e mode_o
);
  assign mode_o = decode_mode(clr_ni, we_ni, oe_ni);
endmodule

// File: rtl/tagram_clr_timer.sv
module tagram_clr_timer #(
  parameter int unsigned RECOV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  output logic busy_o
);
  localparam int unsigned CNT_W = (RECOV < 1) ? 1 : $clog2(RECOV + 1);

  generate
    if (RECOV == 0) begin : g_no_recov
      assign busy_o = 1'b0;
    end else begin : g_recov
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (!clr_ni)      cnt_q <= CNT_W'(RECOV);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
      assign busy_o = (cnt_q != '0);
    end
  endgenerate
endmodule

// File: rtl/tagram_store.sv
module tagram_store #(
  parameter int unsigned TAG_W = 12,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flash_clr_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_valid_i,
  input  logic             wr_dirty_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic             rd_valid_o,
  output logic             rd_dirty_o
);
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] dirty_q;

  // tag words survive a flash clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < int'(DEPTH); e++) tag_q[e] <= '0;
    end else if (wr_en_i) begin
      tag_q[idx_i] <= wr_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (flash_clr_i) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[idx_i] <= wr_valid_i;
      dirty_q[idx_i] <= wr_dirty_i;
    end
  end

  assign rd_tag_o   = tag_q[idx_i];
  assign rd_valid_o = valid_q[idx_i];
  assign rd_dirty_o = dirty_q[idx_i];
endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp #(
  parameter int unsigned TAG_W = 12
) (
  input  logic [TAG_W-1:0] a_i,
  input  logic [TAG_W-1:0] b_i,
  output logic             eq_o
);
  logic [TAG_W-1:0] same;
  generate
    for (genvar g = 0; g < int'(TAG_W); g++) begin : g_bit
      assign same[g] = ~(a_i[g] ^ b_i[g]);
    end
  endgenerate
  assign eq_o = &same;
endmodule

// File: rtl/tag_ram_cmp.sv
module tag_ram_cmp
  import tagram_pkg::*;
#(
  parameter int unsigned TAG_W     = 12,
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned CLR_RECOV = 3,
  localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             valid_i,
  input  logic             dirty_i,
  input  logic             we_ni,
  input  logic             oe_ni,
  input  logic             clr_ni,
  output logic [TAG_W-1:0] tag_o,
  output logic             tag_oe_o,
  output logic             match_o,
  output logic             valid_o,
  output logic             dirty_o
);
  tag_mode_e        mode;
  logic             busy;
  logic             wr_en;
  logic [TAG_W-1:0] rd_tag;
  logic             rd_valid;
  logic             rd_dirty;
  logic             tag_eq;

  tagram_mode_dec u_dec (
    .clr_ni (clr_ni),
    .we_ni  (we_ni),
    .oe_ni  (oe_ni),
    .mode_o (mode)
  );

  tagram_clr_timer #(.RECOV(CLR_RECOV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .busy_o (busy)
  );

  assign wr_en = (mode == MODE_WRITE) && !busy;

  tagram_store #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flash_clr_i (mode == MODE_CLEAR),
    .wr_en_i     (wr_en),
    .idx_i       (idx_i),
    .wr_tag_i    (tag_i),
    .wr_valid_i  (valid_i),
    .wr_dirty_i  (dirty_i),
    .rd_tag_o    (rd_tag),
    .rd_valid_o  (rd_valid),
    .rd_dirty_o  (rd_dirty)
  );

  tagram_cmp #(.TAG_W(TAG_W)) u_cmp (
    .a_i  (tag_i),
    .b_i  (rd_tag),
    .eq_o (tag_eq)
  );

  always_comb begin
    tag_o    = '0;
    tag_oe_o = 1'b0;
    match_o  = 1'b0;
    valid_o  = 1'b0;
    dirty_o  = 1'b0;
    unique case (mode)
      MODE_CLEAR: ;
      MODE_WRITE: begin
        valid_o = valid_i;
        dirty_o = dirty_i;
      end
      MODE_READ, MODE_ILLEGAL: begin
        tag_oe_o = 1'b1;
        tag_o    = rd_tag;
        valid_o  = rd_valid;
        dirty_o  = rd_dirty;
      end
      MODE_COMPARE: begin
        match_o = rd_valid & tag_eq;
        valid_o = rd_valid;
        dirty_o = rd_dirty;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tagram_chk.sv
module tagram_chk #(
  parameter int unsigned TAG_W = 12,
  parameter int unsigned IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] idx_i,
  input logic             valid_i,
  input logic             dirty_i,
  input logic             we_ni,
  input logic             oe_ni,
  input logic             clr_ni,
  input logic [TAG_W-1:0] tag_o,
  input logic             tag_oe_o,
  input logic             match_o,
  input logic             valid_o,
  input logic             dirty_o
);
  a_r7_clear_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> !match_o && !valid_o && !dirty_o && !tag_oe_o);

  a_r2_write_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_ni && oe_ni && clr_ni) |-> valid_o == valid_i && dirty_o == dirty_i && !match_o);

  a_r5_readback_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && clr_ni) |-> tag_oe_o && !match_o);

  a_r3_hit_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> valid_o && we_ni && oe_ni && clr_ni);

  // recovery is at least one edge, so a write one edge after the clear is lost
  a_r8_recov_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!clr_ni, 2) && clr_ni && we_ni && oe_ni) |-> !valid_o);

  a_r6_illegal_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!we_ni && !oe_ni && clr_ni) && !oe_ni && clr_ni && idx_i == $past(idx_i))
      |-> tag_o == $past(tag_o));

  a_r10_bus_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_oe_o |-> tag_o == '0);
endmodule

bind tag_ram_cmp tagram_chk #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .idx_i    (idx_i),
  .valid_i  (valid_i),
  .dirty_i  (dirty_i),
  .we_ni    (we_ni),
  .oe_ni    (oe_ni),
  .clr_ni   (clr_ni),
  .tag_o    (tag_o),
  .tag_oe_o (tag_oe_o),
  .match_o  (match_o),
  .valid_o  (valid_o),
  .dirty_o  (dirty_o)
);

// File: tb/tb_tag_ram_cmp.sv
module tb_tag_ram_cmp;
  localparam int TW = 6;
  localparam int DP = 16;
  localparam int RC = 3;
  localparam int IW = $clog2(DP);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [TW-1:0] tag = '0;
  logic          v_in = 1'b0, d_in = 1'b0;
  logic          we_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1;
  logic [TW-1:0] tag_o;
  logic          tag_oe, match, v_out, d_out;

  int total = 0, bad = 0;
  bit done = 0;

  logic [TW-1:0] m_tag [DP];
  bit            m_v [DP];
  bit            m_d [DP];
  int            m_busy = 0;

  always #4 clk = ~clk;

  tag_ram_cmp #(.TAG_W(TW), .DEPTH(DP), .CLR_RECOV(RC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .idx_i(idx), .tag_i(tag),
    .valid_i(v_in), .dirty_i(d_in), .we_ni(we_n), .oe_ni(oe_n), .clr_ni(clr_n),
    .tag_o(tag_o), .tag_oe_o(tag_oe), .match_o(match), .valid_o(v_out), .dirty_o(d_out)
  );

  function automatic logic [TW-1:0] pat(int i);
    return TW'(i * 37 + 5);
  endfunction

  task automatic check_now(string ph);
    logic [TW-1:0] e_tag = '0;
    logic e_oe = 0, e_m = 0, e_v = 0, e_d = 0;
    string rq;
    if (!clr_n) rq = "R7";
    else if (!we_n && oe_n) begin rq = "R2"; e_v = v_in; e_d = d_in; end
    else if (!oe_n) begin
      rq = we_n ? "R5" : "R6";
      e_oe = 1; e_tag = m_tag[idx]; e_v = m_v[idx]; e_d = m_d[idx];
    end else begin
      rq = "R3"; e_v = m_v[idx]; e_d = m_d[idx];
      e_m = m_v[idx] && (tag == m_tag[idx]);
    end
    total++;
    if ({match, v_out, d_out, tag_oe, tag_o} !== {e_m, e_v, e_d, e_oe, e_tag}) begin
      bad++;
      $display("FAIL %s (%s) idx=%0d m/v/d/oe/tag got %b%b%b%b %h exp %b%b%b%b %h",
               rq, ph, idx, match, v_out, d_out, tag_oe, tag_o, e_m, e_v, e_d, e_oe, e_tag);
    end
  endtask

  task automatic cyc(bit we, bit oe, bit cl, int i, logic [TW-1:0] t, bit v, bit d, string ph);
    @(negedge clk);
    we_n = we; oe_n = oe; clr_n = cl; idx = IW'(i); tag = t; v_in = v; d_in = d;
    #1 check_now(ph);
    @(posedge clk);
    if (!cl) begin
      for (int e = 0; e < DP; e++) begin m_v[e] = 0; m_d[e] = 0; end
      m_busy = RC;
    end else begin
      if (!we && oe && m_busy == 0) begin m_tag[i] = t; m_v[i] = v; m_d[i] = d; end
      if (m_busy > 0) m_busy--;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < DP; e++) begin m_tag[e] = '0; m_v[e] = 0; m_d[e] = 0; end
    #21 check_now("R9 during reset");
    @(negedge clk) rst_ni = 1'b1;

    // R9: first write after reset lands, rest still invalid
    cyc(0, 1, 1, 5, 6'h2a, 1, 1, "R9 first write");
    for (int i = 0; i < DP; i++) cyc(1, 1, 1, i, 6'h2a, 0, 0, "R9 R4 after reset");

    // R1/R2: fill every entry
    for (int i = 0; i < DP; i++) cyc(0, 1, 1, i, pat(i), (i % 3) != 0, i[0], "R1 fill");

    // R3/R4: compare hits, misses on low and high bit
    for (int i = 0; i < DP; i++) begin
      cyc(1, 1, 1, i, pat(i), 0, 0, "R3 hit");
      cyc(1, 1, 1, i, pat(i) ^ 6'h01, 0, 0, "R3 miss lsb");
      cyc(1, 1, 1, i, pat(i) ^ 6'h20, 0, 0, "R3 miss msb");
    end
    // full tag sweep on one valid entry
    for (int t = 0; t < (1 << TW); t++) cyc(1, 1, 1, 1, TW'(t), 0, 0, "R3 sweep");

    // R5/R10: readback every entry
    for (int i = 0; i < DP; i++) cyc(1, 0, 1, i, '0, 0, 0, "R5 R10 readback");

    // R6: forbidden combination must not store
    cyc(0, 0, 1, 4, 6'h3f, 1, 1, "R6 illegal");
    cyc(1, 0, 1, 4, '0, 0, 0, "R6 readback after");
    cyc(1, 1, 1, 4, 6'h3f, 0, 0, "R6 no hit on new tag");

    // R7/R8: clear then writes during lockout and just after
    cyc(1, 1, 0, 2, pat(2), 0, 0, "R7 clear");
    cyc(0, 1, 0, 3, 6'h11, 1, 1, "R7 write during clear");
    for (int k = 0; k <= RC; k++) cyc(0, 1, 1, 8 + k, 6'h30 + TW'(k), 1, 1, "R8 lockout");
    for (int i = 0; i < DP; i++) begin
      cyc(1, 0, 1, i, '0, 0, 0, "R7 R8 tags kept");
      cyc(1, 1, 1, i, m_tag[i], 0, 0, "R7 R8 hit only post-lockout");
    end

    // R4: dirty set, then cleared reads 0
    cyc(0, 1, 1, 6, 6'h05, 1, 1, "R4 dirty write");
    cyc(1, 1, 1, 6, 6'h05, 0, 0, "R4 dirty set");
    cyc(1, 1, 0, 6, 6'h05, 0, 0, "R7 clear again");
    cyc(1, 1, 1, 6, 6'h05, 0, 0, "R4 dirty cleared");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule